// File: doc/BRIEF.md
# Staged Reset Sequencer with Power-Up Timer

This block keeps a system reset asserted until both supply monitors report a good level and a chain of delays has run out. It runs from a free-running timebase clock. It receives two digitized comparator levels: one says the supply is above the power-on threshold, the other says it is above the brown-out threshold. Once the power-on level has been good for a fixed extension time, the sequencer waits for the brown-out level. It then counts a brown-out extension, followed by a power-up delay picked by a 3-bit select. Only after that does it release the reset. A new rise of the brown-out level restarts the combined brown-out and power-up wait from the beginning.

Two sticky flags record why the reset happened. One marks a power-on event and the other marks a brown-out event. Software clears a flag by writing zero to its bit. All delays are counts of timebase cycles, derived from a cycles-per-microsecond parameter and a microseconds-per-millisecond scale.

Top module: `rst_seq`

## Requirements
- R1: Each good input passes through two synchronizer flops. A low level reaches `sys_reset_o` on the third rising clock edge after it is applied, and it aborts any delay in progress.
- R2: Once the power-on level is seen good, the power-on extension of POR_EXT_US*TICKS_PER_US cycles runs, and one further cycle is spent before the brown-out level is examined. From power-on rise to release therefore takes 4 + POR + BOR + PWRT cycles, where POR, BOR and PWRT are the three phase lengths in cycles.
- R3: Once the brown-out level is seen good, the brown-out extension of BOR_EXT_US*TICKS_PER_US cycles runs. From a brown-out rise to release takes 3 + BOR + PWRT cycles.
- R4: The power-up delay follows the brown-out extension. Select code k (0..7) gives 0, 2, 4, 8, 16, 32, 64 or 128 ms, that is 2^k ms for k>0, each ms being US_PER_MS*TICKS_PER_US cycles. Code 0 adds no delay.
- R5: A fresh rise of the brown-out level restarts the brown-out extension and the power-up delay from zero, even when an earlier sequence was part-way through.
- R6: The select is captured when the power-up delay begins. Later changes have no effect on the running delay.
- R7: `status_o[0]` is the sticky power-on flag. A low power-on level sets both `status_o[0]` and `status_o[1]`.
- R8: `status_o[1]` is the sticky brown-out flag. A low brown-out level with a good power-on level sets `status_o[1]` only.
- R9: A write with `stat_wr_en` clears each flag whose `stat_wr_data` bit is 0 and leaves flags whose bit is 1 unchanged. A set condition in the same cycle wins over the clear.
- R10: While `rst_n` is low, `sys_reset_o` is 1 and `status_o` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer |
| por_good_in | input | 1 | Asynchronous power-on-threshold-good level |
| bor_good_in | input | 1 | Asynchronous brown-out-threshold-good level |
| pwrt_sel | input | 3 | Power-up delay select code |
| stat_wr_en | input | 1 | Status register write strobe |
| stat_wr_data | input | 2 | Status write data; a 0 bit clears the flag |
| sys_reset_o | output | 1 | System reset, 1 = held |
| status_o | output | 2 | Bit 0 power-on flag, bit 1 brown-out flag |

## Verification
The bench builds the block with TICKS_PER_US=1 and US_PER_MS=4. This keeps the 30-cycle and 100-cycle extensions, and makes the longest 128 ms power-up setting last only 512 cycles. With these values all eight select codes, a restart in the middle of a power-up delay, a select change during the delay and a full power-on cycle fit within a short run. Release cycles are measured from the edge at which an input is applied, against the closed-form counts in R2 and R3.

// File: rtl/rst_seq_pkg.sv
// Shared types and helpers for the reset sequencer.
// Assumes select codes are 3 bits wide; code 0 means no power-up delay.
package rst_seq_pkg;

    // Phases of the reset sequence, in the order they are normally visited.
    typedef enum logic [2:0] {
        PH_WAIT_PWR  = 3'd0,
        PH_PWR_EXT   = 3'd1,
        PH_WAIT_SUPP = 3'd2,
        PH_SUPP_EXT  = 3'd3,
        PH_PWRUP     = 3'd4,
        PH_RUN       = 3'd5
    } phase_e;

    // Power-up delay in milliseconds for a select code: 0, then 2^code.
    function automatic int unsigned pwrup_ms(input logic [2:0] code);
        if (code == 3'd0) return 0;
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/rst_seq_sync.sv
// Two-flop synchronizer for a vector of independent level signals.
// Assumes each bit is a slow level; no multi-bit coherency is implied.
module rst_seq_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1;

    // Two register stages; both clear to "not good" under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q_sync <= '0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/rst_seq_timer.sv
// Loadable down-counter shared by all delay phases.
// Loading N-1 makes the zero flag appear after N cycles in the phase.
module rst_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          at_zero
);

    logic [CW-1:0] cnt;

    // Load takes priority; otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign at_zero = (cnt == '0);

endmodule

// File: rtl/rst_seq_status.sv
// Sticky cause flags: bit 0 power-on, bit 1 brown-out.
// A write clears flags whose data bit is 0; set requests win over clears.
module rst_seq_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_pwr,
    input  logic       set_supp,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic [1:0] flags
);

    logic [1:0] keep_mask;
    logic [1:0] set_vec;

    // Build the keep mask from a write and the set vector from causes.
    always_comb begin
        keep_mask = wr_en ? wr_data : 2'b11;
        set_vec   = {set_supp | set_pwr, set_pwr};
    end

    // Flags come up set under reset, since reset implies power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= 2'b11;
        end else begin
            flags <= (flags & keep_mask) | set_vec;
        end
    end

endmodule

// File: rtl/rst_seq.sv
// Staged reset sequencer: power-on extension, brown-out extension and a
// selectable power-up delay, then release of the system reset.
// Assumes all delay lengths are at least one cycle except the power-up
// delay, which may be zero. The brown-out level is examined only after
// the power-on extension has run out.
module rst_seq #(
    parameter int TICKS_PER_US = 16,
    parameter int US_PER_MS    = 1000,
    parameter int POR_EXT_US   = 30,
    parameter int BOR_EXT_US   = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_good_in,
    input  logic       bor_good_in,
    input  logic [2:0] pwrt_sel,
    input  logic       stat_wr_en,
    input  logic [1:0] stat_wr_data,
    output logic       sys_reset_o,
    output logic [1:0] status_o
);
    import rst_seq_pkg::*;

    localparam int PWR_CYC   = POR_EXT_US * TICKS_PER_US;
    localparam int SUPP_CYC  = BOR_EXT_US * TICKS_PER_US;
    localparam int MS_CYC    = US_PER_MS * TICKS_PER_US;
    localparam int PWRUP_MAX = 128 * MS_CYC;
    localparam int EXT_MAX   = (PWR_CYC > SUPP_CYC) ? PWR_CYC : SUPP_CYC;
    localparam int ALL_MAX   = (EXT_MAX > PWRUP_MAX) ? EXT_MAX : PWRUP_MAX;
    localparam int CW        = $clog2(ALL_MAX + 1);

    logic [1:0]    good_sync;
    logic          pwr_ok;
    logic          supp_ok;
    phase_e        phase_q;
    phase_e        phase_d;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic [CW-1:0] pwrup_cyc;

    rst_seq_sync #(.WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({bor_good_in, por_good_in}),
        .q_sync  (good_sync)
    );

    assign pwr_ok  = good_sync[0];
    assign supp_ok = good_sync[1];

    rst_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .at_zero  (tmr_zero)
    );

    // Power-up length in cycles for the current select code.
    always_comb begin
        pwrup_cyc = CW'(pwrup_ms(pwrt_sel) * MS_CYC);
    end

    // Next-phase and timer-load decision; low levels abort at once.
    always_comb begin
        phase_d  = phase_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!pwr_ok) begin
            phase_d = PH_WAIT_PWR;
        end else begin
            unique case (phase_q)
                PH_WAIT_PWR: begin
                    phase_d  = PH_PWR_EXT;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(PWR_CYC - 1);
                end
                PH_PWR_EXT: begin
                    if (tmr_zero) phase_d = PH_WAIT_SUPP;
                end
                PH_WAIT_SUPP: begin
                    if (supp_ok) begin
                        phase_d  = PH_SUPP_EXT;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(SUPP_CYC - 1);
                    end
                end
                PH_SUPP_EXT: begin
                    if (!supp_ok) begin
                        phase_d = PH_WAIT_SUPP;
                    end else if (tmr_zero) begin
                        if (pwrup_cyc == '0) begin
                            phase_d = PH_RUN;
                        end else begin
                            phase_d  = PH_PWRUP;
                            tmr_load = 1'b1;
                            tmr_val  = pwrup_cyc - 1'b1;
                        end
                    end
                end
                PH_PWRUP: begin
                    if (!supp_ok)      phase_d = PH_WAIT_SUPP;
                    else if (tmr_zero) phase_d = PH_RUN;
                end
                PH_RUN: begin
                    if (!supp_ok) phase_d = PH_WAIT_SUPP;
                end
                default: phase_d = PH_WAIT_PWR;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_WAIT_PWR;
        else        phase_q <= phase_d;
    end

    assign sys_reset_o = (phase_q != PH_RUN);

    rst_seq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_pwr  (!pwr_ok),
        .set_supp (!supp_ok),
        .wr_en    (stat_wr_en),
        .wr_data  (stat_wr_data),
        .flags    (status_o)
    );

endmodule

// File: rtl/rst_seq_chk.sv
// Property checker for rst_seq, attached by bind. Relates port values
// over time; the third-past sample matches the two-flop input path.
module rst_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       por_good_in,
    input logic       bor_good_in,
    input logic       stat_wr_en,
    input logic [1:0] stat_wr_data,
    input logic       sys_reset_o,
    input logic [1:0] status_o
);

    AST_RUN_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_reset_o |-> ($past(por_good_in, 3) && $past(bor_good_in, 3))); // R1

    AST_PWR_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && !(stat_wr_en && !stat_wr_data[0])) |=> status_o[0]); // R7

    AST_SUPP_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[1] && !(stat_wr_en && !stat_wr_data[1])) |=> status_o[1]); // R8

    AST_PWR_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> !$past(por_good_in, 3)); // R7

    AST_SUPP_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[1]) |-> (!$past(por_good_in, 3) || !$past(bor_good_in, 3))); // R8

endmodule

bind rst_seq rst_seq_chk u_rst_seq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .por_good_in  (por_good_in),
    .bor_good_in  (bor_good_in),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_data (stat_wr_data),
    .sys_reset_o  (sys_reset_o),
    .status_o     (status_o)
);

// File: tb/rst_seq_bench.sv
module rst_seq_bench;
    localparam int TPU = 1;
    localparam int UPM = 4;
    localparam int POR_N = 30 * TPU;
    localparam int BOR_N = 100 * TPU;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_in = 1'b0;
    logic       bor_in = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_data = 2'b00;
    logic       sys_reset;
    logic [1:0] status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rst_seq #(.TICKS_PER_US(TPU), .US_PER_MS(UPM), .POR_EXT_US(30), .BOR_EXT_US(100)) u_rst_seq (
        .clk(clk), .rst_n(rst_n), .por_good_in(por_in), .bor_good_in(bor_in),
        .pwrt_sel(sel), .stat_wr_en(wr_en), .stat_wr_data(wr_data),
        .sys_reset_o(sys_reset), .status_o(status)
    );

    function automatic int pwrup_len(input int code);
        if (code == 0) return 0;
        return (2 ** code) * UPM * TPU;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: input history queues, a phase number and an
    // elapsed-cycle count per phase.
    bit q_por[$];
    bit q_bor[$];
    int m_ph = 0;
    int m_el = 0;
    int m_len = 0;
    int m_flags = 3;

    always @(posedge clk) begin
        bit sp, sb;
        if (!rst_n) begin
            q_por = '{0, 0};
            q_bor = '{0, 0};
            m_ph = 0; m_el = 0; m_flags = 3;
        end else begin
            sp = q_por[0];
            sb = q_bor[0];
            if (wr_en) m_flags = m_flags & int'(wr_data);
            if (!sp) m_flags = 3;
            else if (!sb) m_flags = m_flags | 2;
            if (!sp) begin
                m_ph = 0;
            end else begin
                case (m_ph)
                    0: begin m_ph = 1; m_el = 0; end
                    1: begin if (m_el == POR_N - 1) m_ph = 2; else m_el++; end
                    2: begin if (sb) begin m_ph = 3; m_el = 0; end end
                    3: begin
                        if (!sb) m_ph = 2;
                        else if (m_el == BOR_N - 1) begin
                            m_len = pwrup_len(int'(sel));
                            m_el = 0;
                            m_ph = (m_len == 0) ? 5 : 4;
                        end else m_el++;
                    end
                    4: begin
                        if (!sb) m_ph = 2;
                        else if (m_el == m_len - 1) m_ph = 5;
                        else m_el++;
                    end
                    default: if (!sb) m_ph = 2;
                endcase
            end
            void'(q_por.pop_front());
            void'(q_bor.pop_front());
            q_por.push_back(por_in);
            q_bor.push_back(bor_in);
        end
    end

    // Every-cycle comparison against the reference.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tag;
            case (m_ph)
                1: tag = "R2";
                2, 3: tag = "R3";
                4: tag = "R4";
                default: tag = "R1";
            endcase
            check(sys_reset == (m_ph != 5), tag, int'(sys_reset), int'(m_ph != 5));
            check(int'(status) == m_flags, "R7", int'(status), m_flags);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_release(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sys_reset && n < 3000);
    endtask

    task automatic write_status(input logic [1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 2'b00;
    endtask

    initial begin
        int n;
        tick(3);
        check(sys_reset == 1'b1, "R10", int'(sys_reset), 1);
        check(status == 2'b11, "R10", int'(status), 3);
        rst_n = 1'b1;
        tick(5);

        // Power-on sequence with select 3.
        sel = 3'd3;
        bor_in = 1'b1;
        por_in = 1'b1;
        wait_release(n);
        check(n == 4 + POR_N + BOR_N + pwrup_len(3), "R2", n, 4 + POR_N + BOR_N + pwrup_len(3));

        // Clear both flags; then write ones, which change nothing.
        write_status(2'b00);
        check(status == 2'b00, "R9", int'(status), 0);
        write_status(2'b11);
        check(status == 2'b00, "R9", int'(status), 0);

        // Brown-out alone for every select code.
        for (int c = 0; c < 8; c++) begin
            sel = 3'(c);
            bor_in = 1'b0;
            tick(6);
            check(status == 2'b10, "R8", int'(status), 2);
            write_status(2'b00);
            check(status == 2'b10, "R9", int'(status), 2);
            bor_in = 1'b1;
            wait_release(n);
            check(n == 3 + BOR_N + pwrup_len(c), "R4", n, 3 + BOR_N + pwrup_len(c));
            write_status(2'b00);
            check(status == 2'b00, "R9", int'(status), 0);
        end

        // Restart in the middle of a power-up delay.
        sel = 3'd7;
        bor_in = 1'b0;
        tick(6);
        bor_in = 1'b1;
        tick(200);
        bor_in = 1'b0;
        tick(4);
        bor_in = 1'b1;
        wait_release(n);
        check(n == 3 + BOR_N + pwrup_len(7), "R5", n, 3 + BOR_N + pwrup_len(7));

        // Select changes during the power-up delay are ignored.
        sel = 3'd5;
        bor_in = 1'b0;
        tick(6);
        bor_in = 1'b1;
        tick(110);
        sel = 3'd0;
        wait_release(n);
        check(n + 110 == 3 + BOR_N + pwrup_len(5), "R6", n + 110, 3 + BOR_N + pwrup_len(5));

        // Partial clear: bit 1 written 1 keeps the brown-out flag.
        write_status(2'b10);
        check(status == 2'b10, "R9", int'(status), 2);
        write_status(2'b00);

        // Power-on drop: reset asserts on the third edge.
        por_in = 1'b0;
        tick(2);
        check(sys_reset == 1'b0, "R1", int'(sys_reset), 0);
        tick(1);
        check(sys_reset == 1'b1, "R1", int'(sys_reset), 1);
        tick(2);
        check(status == 2'b11, "R7", int'(status), 3);
        sel = 3'd1;
        por_in = 1'b1;
        wait_release(n);
        check(n == 4 + POR_N + BOR_N + pwrup_len(1), "R2", n, 4 + POR_N + BOR_N + pwrup_len(1));

        // Brown-out level falling during power-on extension is not examined.
        por_in = 1'b0;
        tick(6);
        write_status(2'b00);
        check(status == 2'b11, "R7", int'(status), 3);
        por_in = 1'b1;
        tick(10);
        bor_in = 1'b0;
        tick(10);
        bor_in = 1'b1;
        wait_release(n);
        check(n == 4 + POR_N + BOR_N + pwrup_len(1) - 20, "R3", n, 4 + POR_N + BOR_N + pwrup_len(1) - 20);

        tick(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule